// File: doc/BRIEF.md
# Ordered Store Buffer with Selectable Memory Consistency

This block sits between an in-order core and its data cache. Every store the core retires is placed in a small FIFO. The FIFO writes its entries into the cache one at a time, oldest first. Because of this, all writes reach the cache in program order in either ordering mode.

Loads are handled according to a run-time ordering mode:

- **Sequential-consistency mode.** A load waits until every earlier store has been performed in the cache. Only then is it sent to the cache.
- **Total-store-order mode.** A load may pass stores that are still waiting in the buffer. If the load address matches a buffered store, the youngest matching store supplies the data directly. Otherwise the load goes straight to the cache.

The core presents at most one request per cycle. Requests are held by a valid/ready handshake. A load completes in the cycle its ready is high, and the data is presented in that same cycle.

The cache side has two request channels, each held until the cache signals completion:

- a drain channel, which writes the oldest buffered store;
- a load channel, which reads one word.

A hit can complete in the same cycle the request appears. A miss completes after however many cycles the cache takes.

Top module: `store_order_buf`

## Requirements
- R1: During and right after reset the buffer is empty: `empty_o` is 1, `drain_valid_o` is 0 and `load_valid_o` is 0. The ordering mode resets to sequential consistency.
- R2: A store request (`req_write_i`=1) is accepted in the same cycle, with `req_ready_o`=1, whenever fewer than DEPTH entries are buffered, in either mode. When DEPTH entries are held, `req_ready_o` stays 0 for a store until an entry drains.
- R3: Buffered stores are written to the cache over the drain channel strictly in the order the core issued them. The head entry is removed at the clock edge that ends a cycle in which `drain_valid_o` and `drain_done_i` are both 1.
- R4: While `drain_valid_o` is 1 and `drain_done_i` is 0, `drain_valid_o`, `drain_addr_o` and `drain_data_o` hold their values into the next cycle.
- R5: In total-store-order mode, a load whose word address matches a buffered store completes in the cycle it is presented. The data comes from the youngest matching entry, and the cache load channel is not used.
- R6: In total-store-order mode, a load with no matching buffered store drives `load_valid_o`=1 with `load_addr_o` equal to its address, even while stores are still buffered. It completes in the first cycle `load_done_i` is 1, returning `load_data_i`; a hit therefore costs no stall cycle.
- R7: In sequential-consistency mode, a load is not sent to the cache and gets `req_ready_o`=0 while any store is buffered. It is issued in the first cycle the buffer is empty.
- R8: The mode input (`mode_tso_i`: 1 = total store order, 0 = sequential consistency) is taken into the active mode only at a clock edge where the buffer is empty. While entries are buffered, the active mode keeps its value.
- R9: `empty_o` is 1 exactly when no store is buffered, and `drain_valid_o` is 1 exactly when at least one is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_tso_i | input | 1 | Requested ordering mode, 1 = total store order |
| req_valid_i | input | 1 | Core request valid |
| req_write_i | input | 1 | 1 = store, 0 = load |
| req_addr_i | input | 16 | Word address of the request |
| req_wdata_i | input | 32 | Store data |
| req_ready_o | output | 1 | Request accepted / load completes this cycle |
| rd_data_o | output | 32 | Load data, valid with req_ready_o on a load |
| empty_o | output | 1 | No store buffered |
| drain_valid_o | output | 1 | Oldest store offered to the cache |
| drain_addr_o | output | 16 | Address of the store being drained |
| drain_data_o | output | 32 | Data of the store being drained |
| drain_done_i | input | 1 | Cache has performed the drained store |
| load_valid_o | output | 1 | Load request to the cache |
| load_addr_o | output | 16 | Load address to the cache |
| load_done_i | input | 1 | Cache load complete |
| load_data_i | input | 32 | Cache load data |

## Verification
The bench builds the block with its default depth of four entries. At that depth, four stores fill the buffer, so the full-buffer stall and several same-address duplicates fit in one short vector table.

The cache model's drain and load latencies are bench variables. Setting a latency of zero produces same-cycle hits, and a large latency pins stores in the buffer. Together these expose the difference between the two modes:

- the exact stall count of a sequential-consistency load behind a missing store;
- forwarding past a pending store;
- a mode change requested while entries remain, which must not take effect until the buffer is empty.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;

    localparam int SB_AW = 16;
    localparam int SB_DW = 32;

    typedef enum logic {
        ORD_SC  = 1'b0,
        ORD_TSO = 1'b1
    } order_mode_e;

    typedef struct packed {
        logic             vld;
        logic [SB_AW-1:0] addr;
        logic [SB_DW-1:0] data;
    } sb_entry_t;

    typedef struct packed {
        logic             vld;
        logic             we;
        logic [SB_AW-1:0] addr;
        logic [SB_DW-1:0] wdata;
    } core_req_t;

    // Ring index: (base + off) modulo depth
    function automatic int unsigned ring_add(int unsigned base, int unsigned off,
                                             int unsigned depth);
        return (base + off) % depth;
    endfunction

endpackage

// File: rtl/sbuf_fifo.sv
module sbuf_fifo import sbuf_pkg::*; #(
    parameter int DEPTH = 4,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [SB_AW-1:0] push_addr,
    input  logic [SB_DW-1:0] push_data,
    input  logic             pop,
    output sb_entry_t        slots_o [DEPTH],
    output logic [PW-1:0]    head_o,
    output sb_entry_t        head_ent_o,
    output logic             empty_o,
    output logic             full_o
);

    sb_entry_t     slots_q [DEPTH];
    logic [PW-1:0] head_q;
    logic [PW-1:0] tail_q;
    logic [CW-1:0] count_q;

    function automatic logic [PW-1:0] ptr_next(logic [PW-1:0] p);
        return PW'(ring_add(int'(p), 1, DEPTH));
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                slots_q[i] <= '0;
            end
        end else begin
            if (push) begin
                slots_q[tail_q] <= '{vld: 1'b1, addr: push_addr, data: push_data};
                tail_q          <= ptr_next(tail_q);
            end
            if (pop) begin
                slots_q[head_q].vld <= 1'b0;
                head_q              <= ptr_next(head_q);
            end
            count_q <= count_q + CW'(push) - CW'(pop);
        end
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot_out
            assign slots_o[g] = slots_q[g];
        end
    endgenerate

    assign head_o     = head_q;
    assign head_ent_o = slots_q[head_q];
    assign empty_o    = (count_q == '0);
    assign full_o     = (count_q == CW'(DEPTH));

endmodule

// File: rtl/sbuf_fwd.sv
module sbuf_fwd import sbuf_pkg::*; #(
    parameter int DEPTH = 4,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  sb_entry_t        slots_i [DEPTH],
    input  logic [PW-1:0]    head_i,
    input  logic [SB_AW-1:0] addr_i,
    output logic             hit_o,
    output logic [SB_DW-1:0] data_o
);

    // Walk from oldest to youngest; a later match overrides, so the
    // youngest matching store wins.
    always_comb begin
        logic [PW-1:0] idx;
        hit_o  = 1'b0;
        data_o = '0;
        for (int k = 0; k < DEPTH; k++) begin
            idx = PW'(ring_add(int'(head_i), k, DEPTH));
            if (slots_i[idx].vld && (slots_i[idx].addr == addr_i)) begin
                hit_o  = 1'b1;
                data_o = slots_i[idx].data;
            end
        end
    end

endmodule

// File: rtl/sbuf_ctrl.sv
module sbuf_ctrl import sbuf_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_tso_i,
    input  core_req_t        req_i,
    input  logic             buf_empty_i,
    input  logic             buf_full_i,
    input  logic             fwd_hit_i,
    input  logic [SB_DW-1:0] fwd_data_i,
    input  logic             load_done_i,
    input  logic [SB_DW-1:0] load_data_i,
    output logic             push_o,
    output logic             req_ready_o,
    output logic [SB_DW-1:0] rd_data_o,
    output logic             load_valid_o,
    output order_mode_e      mode_q_o
);

    order_mode_e mode_q;
    logic        is_load;
    logic        is_store;
    logic        use_fwd;
    logic        may_issue;

    // Mode is only re-sampled while nothing is buffered
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= ORD_SC;
        end else if (buf_empty_i) begin
            mode_q <= mode_tso_i ? ORD_TSO : ORD_SC;
        end
    end

    always_comb begin
        is_load   = req_i.vld && !req_i.we;
        is_store  = req_i.vld && req_i.we;
        push_o    = is_store && !buf_full_i;
        use_fwd   = is_load && (mode_q == ORD_TSO) && fwd_hit_i;
        may_issue = (mode_q == ORD_TSO) || buf_empty_i;
        load_valid_o = is_load && !use_fwd && may_issue;
        req_ready_o  = push_o || use_fwd || (load_valid_o && load_done_i);
        rd_data_o    = use_fwd ? fwd_data_i : load_data_i;
    end

    assign mode_q_o = mode_q;

endmodule

// File: rtl/store_order_buf.sv
module store_order_buf import sbuf_pkg::*; #(
    parameter int DEPTH = 4,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_tso_i,
    input  logic             req_valid_i,
    input  logic             req_write_i,
    input  logic [SB_AW-1:0] req_addr_i,
    input  logic [SB_DW-1:0] req_wdata_i,
    output logic             req_ready_o,
    output logic [SB_DW-1:0] rd_data_o,
    output logic             empty_o,
    output logic             drain_valid_o,
    output logic [SB_AW-1:0] drain_addr_o,
    output logic [SB_DW-1:0] drain_data_o,
    input  logic             drain_done_i,
    output logic             load_valid_o,
    output logic [SB_AW-1:0] load_addr_o,
    input  logic             load_done_i,
    input  logic [SB_DW-1:0] load_data_i
);

    core_req_t     core_req;
    sb_entry_t     slots [DEPTH];
    sb_entry_t     head_ent;
    logic [PW-1:0] head_ptr;
    logic          buf_empty;
    logic          buf_full;
    logic          push;
    logic          pop;
    logic          fwd_hit;
    logic [SB_DW-1:0] fwd_data;
    order_mode_e   mode_q;

    assign core_req = '{vld: req_valid_i, we: req_write_i,
                        addr: req_addr_i, wdata: req_wdata_i};

    assign pop = !buf_empty && drain_done_i;

    sbuf_fifo #(.DEPTH(DEPTH)) i_fifo (
        .clk        (clk),
        .rst        (rst),
        .push       (push),
        .push_addr  (req_addr_i),
        .push_data  (req_wdata_i),
        .pop        (pop),
        .slots_o    (slots),
        .head_o     (head_ptr),
        .head_ent_o (head_ent),
        .empty_o    (buf_empty),
        .full_o     (buf_full)
    );

    sbuf_fwd #(.DEPTH(DEPTH)) i_fwd (
        .slots_i (slots),
        .head_i  (head_ptr),
        .addr_i  (req_addr_i),
        .hit_o   (fwd_hit),
        .data_o  (fwd_data)
    );

    sbuf_ctrl i_ctrl (
        .clk          (clk),
        .rst          (rst),
        .mode_tso_i   (mode_tso_i),
        .req_i        (core_req),
        .buf_empty_i  (buf_empty),
        .buf_full_i   (buf_full),
        .fwd_hit_i    (fwd_hit),
        .fwd_data_i   (fwd_data),
        .load_done_i  (load_done_i),
        .load_data_i  (load_data_i),
        .push_o       (push),
        .req_ready_o  (req_ready_o),
        .rd_data_o    (rd_data_o),
        .load_valid_o (load_valid_o),
        .mode_q_o     (mode_q)
    );

    assign empty_o       = buf_empty;
    assign drain_valid_o = !buf_empty;
    assign drain_addr_o  = head_ent.addr;
    assign drain_data_o  = head_ent.data;
    assign load_addr_o   = req_addr_i;

endmodule

// File: rtl/sbuf_chk.sv
module sbuf_chk import sbuf_pkg::*; (
    input logic             clk,
    input logic             rst,
    input logic             req_valid_i,
    input logic             req_write_i,
    input logic [SB_AW-1:0] req_addr_i,
    input logic             req_ready_o,
    input logic             empty_o,
    input logic             drain_valid_o,
    input logic [SB_AW-1:0] drain_addr_o,
    input logic [SB_DW-1:0] drain_data_o,
    input logic             drain_done_i,
    input logic             load_valid_o,
    input logic [SB_AW-1:0] load_addr_o,
    input order_mode_e      mode_q
);

    // R1
    rst_state_chk: assert property (@(posedge clk)
        rst |=> (empty_o && !drain_valid_o && !load_valid_o));

    // R2
    store_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && req_write_i && req_ready_o) |=> !empty_o);

    // R4
    drain_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (drain_valid_o && !drain_done_i) |=>
            (drain_valid_o && $stable(drain_addr_o) && $stable(drain_data_o)));

    // R5
    fwd_source_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && !req_write_i && req_ready_o && !load_valid_o) |->
            (!empty_o && mode_q == ORD_TSO));

    // R6
    load_addr_chk: assert property (@(posedge clk) disable iff (rst)
        load_valid_o |-> (req_valid_i && !req_write_i && load_addr_o == req_addr_i));

    // R7
    sc_order_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == ORD_SC && !empty_o) |-> !load_valid_o);

    // R8
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !empty_o |=> (mode_q == $past(mode_q)));

endmodule

bind store_order_buf sbuf_chk i_sbuf_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid_i   (req_valid_i),
    .req_write_i   (req_write_i),
    .req_addr_i    (req_addr_i),
    .req_ready_o   (req_ready_o),
    .empty_o       (empty_o),
    .drain_valid_o (drain_valid_o),
    .drain_addr_o  (drain_addr_o),
    .drain_data_o  (drain_data_o),
    .drain_done_i  (drain_done_i),
    .load_valid_o  (load_valid_o),
    .load_addr_o   (load_addr_o),
    .mode_q        (mode_q)
);

// File: tb/test_store_order_buf.sv
`timescale 1ns/1ps
module test_store_order_buf;

    logic        clk = 1'b0;
    logic        rst;
    logic        mode_tso;
    logic        req_valid;
    logic        req_write;
    logic [15:0] req_addr;
    logic [31:0] req_wdata;
    logic        req_ready;
    logic [31:0] rd_data;
    logic        empty;
    logic        drain_valid;
    logic [15:0] drain_addr;
    logic [31:0] drain_data;
    logic        drain_done;
    logic        load_valid;
    logic [15:0] load_addr;
    logic        load_done;
    logic [31:0] load_data;

    int checks = 0;
    int fails  = 0;
    int drain_lat = 1000;
    int load_lat  = 0;
    int dcnt;
    int lcnt;

    logic [31:0] mem [256];
    logic [15:0] log_addr [16];
    logic [31:0] log_data [16];
    int          log_n;

    always #2.5 clk = ~clk;

    store_order_buf i_store_order_buf (
        .clk(clk), .rst(rst), .mode_tso_i(mode_tso),
        .req_valid_i(req_valid), .req_write_i(req_write),
        .req_addr_i(req_addr), .req_wdata_i(req_wdata),
        .req_ready_o(req_ready), .rd_data_o(rd_data), .empty_o(empty),
        .drain_valid_o(drain_valid), .drain_addr_o(drain_addr),
        .drain_data_o(drain_data), .drain_done_i(drain_done),
        .load_valid_o(load_valid), .load_addr_o(load_addr),
        .load_done_i(load_done), .load_data_i(load_data)
    );

    // Cache model: latency counters, word memory, drain log
    assign drain_done = drain_valid && (dcnt >= drain_lat);
    assign load_done  = load_valid && (lcnt >= load_lat);
    assign load_data  = mem[load_addr[7:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            dcnt  <= 0;
            lcnt  <= 0;
            log_n <= 0;
            for (int i = 0; i < 256; i++) mem[i] <= 32'hA5A5_0000 | i;
        end else begin
            dcnt <= (drain_valid && !drain_done) ? dcnt + 1 : 0;
            lcnt <= (load_valid && !load_done) ? lcnt + 1 : 0;
            if (drain_valid && drain_done) begin
                mem[drain_addr[7:0]] <= drain_data;
                if (log_n < 16) begin
                    log_addr[log_n] <= drain_addr;
                    log_data[log_n] <= drain_data;
                end
                log_n <= log_n + 1;
            end
        end
    end

    typedef struct packed {
        logic        wr;
        logic [15:0] addr;
        logic [31:0] data;
        logic        exp_ready;
        logic        exp_lv;
        logic [31:0] exp_data;
    } vec_t;

    // Total-store-order mode, drains held back by a long drain latency
    localparam vec_t VEC [9] = '{
        '{1'b1, 16'h0010, 32'h0000_0111, 1'b1, 1'b0, 32'h0},
        '{1'b1, 16'h0020, 32'h0000_0222, 1'b1, 1'b0, 32'h0},
        '{1'b1, 16'h0010, 32'h0000_0333, 1'b1, 1'b0, 32'h0},
        '{1'b0, 16'h0010, 32'h0,         1'b1, 1'b0, 32'h0000_0333},
        '{1'b0, 16'h0020, 32'h0,         1'b1, 1'b0, 32'h0000_0222},
        '{1'b0, 16'h0030, 32'h0,         1'b1, 1'b1, 32'hA5A5_0030},
        '{1'b1, 16'h0040, 32'h0000_0444, 1'b1, 1'b0, 32'h0},
        '{1'b1, 16'h0050, 32'h0000_0555, 1'b0, 1'b0, 32'h0},
        '{1'b0, 16'h0040, 32'h0,         1'b1, 1'b0, 32'h0000_0444}
    };

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(logic wr, logic [15:0] a, logic [31:0] d);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
    endtask

    task automatic idle();
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    task automatic wait_empty();
        for (int n = 0; n < 2000 && !empty; n++) @(negedge clk);
    endtask

    // Hold a load until accepted; returns stall cycles
    task automatic hold_load(logic [15:0] a, output int stalls, output logic [31:0] data,
                             output logic early_issue);
        stalls = 0;
        early_issue = 1'b0;
        drive(1'b0, a, 32'h0);
        for (int n = 0; n < 200; n++) begin
            #1;
            if (load_valid && !empty && !i_store_order_buf.mode_tso_i) early_issue = 1'b1;
            if (req_ready) break;
            stalls++;
            @(negedge clk);
        end
        data = rd_data;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int          st;
        logic [31:0] dt;
        logic        early;

        rst = 1'b1;
        mode_tso = 1'b0;
        idle();
        req_addr = '0;
        req_wdata = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 empty during reset", {31'b0, empty}, 32'd1);
        check("R1 no drain during reset", {31'b0, drain_valid}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 empty after reset", {31'b0, empty}, 32'd1);
        check("R1 no load after reset", {31'b0, load_valid}, 32'd0);

        // Switch to total store order while empty
        mode_tso = 1'b1;
        @(negedge clk);

        for (int v = 0; v < 9; v++) begin
            drive(VEC[v].wr, VEC[v].addr, VEC[v].data);
            #1;
            check($sformatf("R2 R5 R6 vector %0d ready", v), {31'b0, req_ready},
                  {31'b0, VEC[v].exp_ready});
            check($sformatf("R5 R6 vector %0d load_valid", v), {31'b0, load_valid},
                  {31'b0, VEC[v].exp_lv});
            if (!VEC[v].wr) check($sformatf("R5 R6 vector %0d data", v), rd_data, VEC[v].exp_data);
            @(negedge clk);
        end
        idle();

        // R4: head entry held while the cache has not completed it
        #1;
        check("R4 drain addr held", {16'b0, drain_addr}, 32'h10);
        check("R4 drain data held", drain_data, 32'h111);
        check("R9 not empty with entries", {31'b0, empty}, 32'd0);

        // R3: release the drains, verify program order
        drain_lat = 0;
        repeat (6) @(negedge clk);
        check("R9 empty after drain", {31'b0, empty}, 32'd1);
        check("R9 no drain when empty", {31'b0, drain_valid}, 32'd0);
        check("R3 drain count", log_n, 32'd4);
        check("R3 drain 0 addr", {16'b0, log_addr[0]}, 32'h10);
        check("R3 drain 0 data", log_data[0], 32'h111);
        check("R3 drain 1 addr", {16'b0, log_addr[1]}, 32'h20);
        check("R3 drain 2 data", log_data[2], 32'h333);
        check("R3 drain 3 addr", {16'b0, log_addr[3]}, 32'h40);
        check("R3 final word in cache", mem[8'h10], 32'h333);

        // R7: sequential consistency, load waits for missing store
        mode_tso = 1'b0;
        @(negedge clk);
        drain_lat = 5;
        load_lat  = 0;
        drive(1'b1, 16'h0060, 32'h0000_0666);
        #1;
        check("R2 SC store no stall", {31'b0, req_ready}, 32'd1);
        @(negedge clk);
        hold_load(16'h0060, st, dt, early);
        check("R7 SC load stall cycles", st, 32'd6);
        check("R7 SC load data", dt, 32'h666);
        check("R7 no early issue", {31'b0, early}, 32'd0);
        @(negedge clk);
        idle();

        // R5/R6: total store order, forward past a missing store
        mode_tso = 1'b1;
        @(negedge clk);
        drive(1'b1, 16'h0070, 32'h0000_0777);
        #1;
        check("R2 TSO store no stall", {31'b0, req_ready}, 32'd1);
        @(negedge clk);
        drive(1'b0, 16'h0070, 32'h0);
        #1;
        check("R5 forward ready", {31'b0, req_ready}, 32'd1);
        check("R5 forward data", rd_data, 32'h777);
        check("R5 no cache load", {31'b0, load_valid}, 32'd0);
        @(negedge clk);
        load_lat = 3;
        drive(1'b0, 16'h0080, 32'h0);
        #1;
        check("R6 bypass load issued", {31'b0, load_valid}, 32'd1);
        check("R6 bypass load addr", {16'b0, load_addr}, 32'h80);
        hold_load(16'h0080, st, dt, early);
        check("R6 miss stall cycles", st, 32'd3);
        check("R6 miss data", dt, 32'hA5A5_0080);
        @(negedge clk);
        idle();
        load_lat = 0;

        // R8: mode change while non-empty is deferred
        wait_empty();
        drain_lat = 1000;
        @(negedge clk);
        drive(1'b1, 16'h0090, 32'h0000_0999);
        @(negedge clk);
        idle();
        mode_tso = 1'b0;
        @(negedge clk);
        drive(1'b0, 16'h0090, 32'h0);
        #1;
        check("R8 mode kept while buffered", {31'b0, req_ready}, 32'd1);
        check("R8 forward still active", rd_data, 32'h999);
        @(negedge clk);
        idle();
        drain_lat = 0;
        repeat (3) @(negedge clk);
        drain_lat = 1000;
        drive(1'b1, 16'h00A0, 32'h0000_0AAA);
        @(negedge clk);
        drive(1'b0, 16'h00B0, 32'h0);
        #1;
        check("R8 SC active after empty", {31'b0, req_ready}, 32'd0);
        check("R8 SC load held", {31'b0, load_valid}, 32'd0);
        @(negedge clk);
        drain_lat = 0;
        hold_load(16'h00B0, st, dt, early);
        check("R7 load after drain data", dt, 32'hA5A5_00B0);
        @(negedge clk);
        idle();

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule